// File: doc/BRIEF.md
# Dual-Channel Saturating Gain Stage

This block sits in a two-lane sample stream running on the converter clock. Every cycle it accepts one 14-bit signed sample per lane, multiplies it by an 8-bit unsigned gain in 4.4 fixed point, and drives one 14-bit signed result per lane. The gain is taken as a positive operand, so the stage can attenuate (gains below 16) or amplify (gains up to 255/16). Products that leave the 14-bit range are pinned to the nearest limit instead of wrapping. The stage behaves like a clipping analog amplifier.

Each lane can optionally pass its input through a four-tap moving average before the gain is applied. The average acts as a simple low-pass filter. It is the floor of the sum of the current sample and the three previous samples, divided by four, so a constant input keeps its level. The input-to-output latency is one clock cycle whether or not averaging is on.

Software reaches the block through a small memory-mapped bus with a one-cycle acknowledge. The bus provides an identification word, two gain registers and a control register that turns averaging on per lane.

Top module: `twin_gain_clamp`

## Requirements
- R1: Each clock edge registers one result per lane from that lane's input in the same cycle. After reset, the gain is 16 and averaging is off, so each output equals its lane's input one cycle later.
- R2: With averaging off, a lane's output is floor(x * k / 16). Here x is the signed input and k is the lane's gain register, read as an unsigned value from 0 to 255. A gain of 24 therefore multiplies by 1.5, and a gain of 0 gives 0.
- R3: A result above 8191 is output as 8191, and a result below -8192 is output as -8192.
- R4: With averaging on, the value scaled in place of x is floor((x[n] + x[n-1] + x[n-2] + x[n-3]) / 4). The history always follows the input whether or not averaging is enabled, and the latency stays at one cycle.
- R5: Bit 0 of the control register at offset 0x100C enables averaging on lane A, and bit 1 enables it on lane B. The two bits act independently, and reads return these two bits with all other bits zero.
- R6: A read of offset 0x1000 returns 0xFE020210. Writes to that offset change nothing.
- R7: The lane A gain is at offset 0x1004 and the lane B gain is at offset 0x1008. A write stores write-data bits 7:0, and a read returns the stored gain zero-extended to 32 bits.
- R8: A write or read request is acknowledged for exactly one cycle, in the cycle after the request. The error output stays low, and read data is zero in any cycle that does not acknowledge a read.
- R9: A read of any offset not listed above returns zero and is still acknowledged. A write to such an offset changes no register.
- R10: While reset is low, and right after it is released, both outputs and the acknowledge are zero, both gains read as 16, the control register reads as 0, and the averaging history is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_n_i | input | 1 | Active-low reset |
| smp_a_i | input | 14 | Lane A input sample, two's complement |
| smp_b_i | input | 14 | Lane B input sample, two's complement |
| smp_a_o | output | 14 | Lane A output sample, two's complement |
| smp_b_o | output | 14 | Lane B output sample, two's complement |
| bus_addr_i | input | ADDR_W (20) | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_wen_i | input | 1 | Write request |
| bus_ren_i | input | 1 | Read request |
| bus_rdata_o | output | 32 | Read data, valid with acknowledge |
| bus_err_o | output | 1 | Error flag, always low |
| bus_ack_o | output | 1 | Access acknowledge |

## Verification
The hardest cases to reach from the ports are the exact clamp boundaries, because they only appear once a gain write has landed and a sample sits precisely on the edge. The stimulus first writes a gain of 24. It then drives 5461, which gives exactly 8191, and 5462, which gives 8193 and must clamp, along with their negative mirrors. Full-scale inputs are driven under a gain of 255. The averaging history is probed by enabling averaging after a run of random samples. That way the first averaged output depends on samples taken while averaging was still off. A reset in the middle of the run confirms that the history and the registers both return to their reset values.

// File: rtl/tgc_pkg.sv
package tgc_pkg;
  parameter int SMP_W  = 14;
  parameter int FACT_W = 8;
  parameter int FRAC_W = 4;
  parameter int BUS_W  = 32;

  localparam int SUM_W  = SMP_W + 2;
  localparam int PROD_W = SMP_W + FACT_W + 1;
  localparam int WIDE_W = PROD_W - FRAC_W;

  localparam logic [15:0] OFS_ID     = 16'h1000;
  localparam logic [15:0] OFS_GAIN_A = 16'h1004;
  localparam logic [15:0] OFS_GAIN_B = 16'h1008;
  localparam logic [15:0] OFS_CTRL   = 16'h100C;
  localparam logic [BUS_W-1:0] ID_WORD = 32'hFE02_0210;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic [FACT_W-1:0]        fact_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam smp_t  SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
  localparam smp_t  SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam wide_t W_MAX   = WIDE_W'((1 << (SMP_W-1)) - 1);
  localparam wide_t W_MIN   = WIDE_W'(-(1 << (SMP_W-1)));
  localparam fact_t UNITY   = fact_t'(1 << FRAC_W);

  // floor of the four-sample mean: widen, add, drop two LSBs
  function automatic smp_t mean4(smp_t a, smp_t b, smp_t c, smp_t d);
    logic signed [SUM_W-1:0] s;
    s = {{2{a[SMP_W-1]}}, a} + {{2{b[SMP_W-1]}}, b}
      + {{2{c[SMP_W-1]}}, c} + {{2{d[SMP_W-1]}}, d};
    return s[SUM_W-1:2];
  endfunction

  // signed sample times zero-extended gain, fraction bits dropped
  function automatic wide_t gain_product(smp_t x, fact_t k);
    logic signed [PROD_W-1:0] xs, ks, p;
    xs = {{(PROD_W-SMP_W){x[SMP_W-1]}}, x};
    ks = {{(PROD_W-FACT_W){1'b0}}, k};
    p  = xs * ks;
    return p[PROD_W-1:FRAC_W];
  endfunction

  function automatic smp_t clamp(wide_t w);
    if (w > W_MAX)      return SMP_MAX;
    else if (w < W_MIN) return SMP_MIN;
    else                return w[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/tgc_lane.sv
module tgc_lane
  import tgc_pkg::*;
#(
  parameter int TAPS = 4
) (
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  smp_t  smp_i,
  input  fact_t fact_i,
  input  logic  avg_en_i,
  output smp_t  smp_o
);
  localparam int HIST_N = TAPS - 1;

  smp_t  hist_q [HIST_N];
  smp_t  mean_w, pick_w;
  wide_t wide_w;
  logic  sat_hi_w, sat_lo_w;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= smp_i;
      for (int i = 1; i < HIST_N; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign mean_w   = mean4(smp_i, hist_q[0], hist_q[1], hist_q[2]);
  assign pick_w   = avg_en_i ? mean_w : smp_i;
  assign wide_w   = gain_product(pick_w, fact_i);
  assign sat_hi_w = (wide_w > W_MAX);
  assign sat_lo_w = (wide_w < W_MIN);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) smp_o <= '0;
    else          smp_o <= clamp(wide_w);
  end

  AST_CLAMP_HI: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sat_hi_w |=> smp_o == SMP_MAX); // R3
  AST_CLAMP_LO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    sat_lo_w |=> smp_o == SMP_MIN); // R3
  AST_UNITY_PASS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fact_i == UNITY && !avg_en_i) |=> smp_o == $past(smp_i)); // R1
  AST_ZERO_GAIN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (fact_i == '0) |=> smp_o == '0); // R2
  AST_FLAT_MEAN: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (avg_en_i && fact_i == UNITY && smp_i == hist_q[0] && hist_q[0] == hist_q[1]
     && hist_q[1] == hist_q[2]) |=> smp_o == $past(smp_i)); // R4
endmodule

// File: rtl/tgc_regs.sv
module tgc_regs
  import tgc_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              wen_i,
  input  logic              ren_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              ack_o,
  output logic              err_o,
  output fact_t             fact_a_o,
  output fact_t             fact_b_o,
  output logic [1:0]        avg_en_o
);
  logic hit_id_w, hit_ga_w, hit_gb_w, hit_ctl_w, hit_any_w;
  logic [BUS_W-1:0] rd_mux_w;

  assign hit_id_w  = (addr_i == ADDR_W'(OFS_ID));
  assign hit_ga_w  = (addr_i == ADDR_W'(OFS_GAIN_A));
  assign hit_gb_w  = (addr_i == ADDR_W'(OFS_GAIN_B));
  assign hit_ctl_w = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_any_w = hit_id_w | hit_ga_w | hit_gb_w | hit_ctl_w;

  always_comb begin
    rd_mux_w = '0;
    if (hit_id_w)  rd_mux_w = ID_WORD;
    if (hit_ga_w)  rd_mux_w = BUS_W'(fact_a_o);
    if (hit_gb_w)  rd_mux_w = BUS_W'(fact_b_o);
    if (hit_ctl_w) rd_mux_w = BUS_W'(avg_en_o);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fact_a_o <= UNITY;
      fact_b_o <= UNITY;
      avg_en_o <= '0;
      ack_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ack_o   <= wen_i | ren_i;
      rdata_o <= ren_i ? rd_mux_w : '0;
      if (wen_i && hit_ga_w)  fact_a_o <= wdata_i[FACT_W-1:0];
      if (wen_i && hit_gb_w)  fact_b_o <= wdata_i[FACT_W-1:0];
      if (wen_i && hit_ctl_w) avg_en_o <= wdata_i[1:0];
    end
  end

  assign err_o = 1'b0;

  AST_ACK_NEXT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wen_i || ren_i) |=> ack_o); // R8
  AST_ACK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(wen_i || ren_i) |=> !ack_o); // R8
  AST_QUIET_RDATA: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !ren_i |=> rdata_o == '0); // R8
  AST_ID_READ: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ren_i && hit_id_w) |=> rdata_o == ID_WORD); // R6
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (ren_i && !hit_any_w) |=> rdata_o == '0); // R9
  AST_MISS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wen_i && !hit_ga_w && !hit_gb_w && !hit_ctl_w)
      |=> ($stable(fact_a_o) && $stable(fact_b_o) && $stable(avg_en_o))); // R9
endmodule

// File: rtl/twin_gain_clamp.sv
module twin_gain_clamp
  import tgc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int LANES  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic signed [SMP_W-1:0]  smp_a_i,
  input  logic signed [SMP_W-1:0]  smp_b_i,
  output logic signed [SMP_W-1:0]  smp_a_o,
  output logic signed [SMP_W-1:0]  smp_b_o,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [BUS_W-1:0]         bus_wdata_i,
  input  logic                     bus_wen_i,
  input  logic                     bus_ren_i,
  output logic [BUS_W-1:0]         bus_rdata_o,
  output logic                     bus_err_o,
  output logic                     bus_ack_o
);
  fact_t      fact_a_w, fact_b_w;
  logic [1:0] avg_en_w;
  smp_t       lane_in  [LANES];
  smp_t       lane_out [LANES];
  fact_t      lane_fact[LANES];

  tgc_regs #(.ADDR_W(ADDR_W)) regs_i (
    .clk_i    (clk_i),
    .rst_n_i  (rst_n_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .wen_i    (bus_wen_i),
    .ren_i    (bus_ren_i),
    .rdata_o  (bus_rdata_o),
    .ack_o    (bus_ack_o),
    .err_o    (bus_err_o),
    .fact_a_o (fact_a_w),
    .fact_b_o (fact_b_w),
    .avg_en_o (avg_en_w)
  );

  assign lane_in[0]   = smp_a_i;
  assign lane_in[1]   = smp_b_i;
  assign lane_fact[0] = fact_a_w;
  assign lane_fact[1] = fact_b_w;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tgc_lane lane_i (
      .clk_i    (clk_i),
      .rst_n_i  (rst_n_i),
      .smp_i    (lane_in[g]),
      .fact_i   (lane_fact[g]),
      .avg_en_i (avg_en_w[g]),
      .smp_o    (lane_out[g])
    );
  end

  assign smp_a_o = lane_out[0];
  assign smp_b_o = lane_out[1];
endmodule

// File: tb/twin_gain_clamp_tb.sv
module twin_gain_clamp_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [13:0] a_i = '0, b_i = '0;
  logic signed [13:0] a_o, b_o;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic wen = 1'b0, ren = 1'b0;
  logic [31:0] rdata;
  logic err, ack;

  int checks = 0;
  int errors = 0;
  string cur_req = "R10";

  // reference model state
  int hist_a[$];
  int hist_b[$];
  int m_gain_a, m_gain_b, m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  twin_gain_clamp dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .smp_a_i(a_i), .smp_b_i(b_i), .smp_a_o(a_o), .smp_b_o(b_o),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wen_i(wen), .bus_ren_i(ren),
    .bus_rdata_o(rdata), .bus_err_o(err), .bus_ack_o(ack)
  );

  function automatic int fdiv(int n, int d);
    int q = n / d;
    if ((n % d) != 0 && n < 0) q = q - 1;
    return q;
  endfunction

  function automatic int ref_lane(int x, int h[$], int k, bit avg);
    int v = avg ? fdiv(x + h[0] + h[1] + h[2], 4) : x;
    int p = fdiv(v * k, 16);
    if (p > 8191) p = 8191;
    if (p < -8192) p = -8192;
    return p;
  endfunction

  function automatic int ref_read(int a);
    case (a)
      'h1000: return 'hFE020210;
      'h1004: return m_gain_a;
      'h1008: return m_gain_b;
      'h100C: return m_ctrl;
      default: return 0;
    endcase
  endfunction

  function automatic void model_reset();
    hist_a = '{0, 0, 0};
    hist_b = '{0, 0, 0};
    m_gain_a = 16; m_gain_b = 16; m_ctrl = 0;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one clock: predict, clock, update model, compare at the falling edge
  task automatic cyc();
    int ea, eb, er;
    bit eack;
    ea = ref_lane(int'(a_i), hist_a, m_gain_a, m_ctrl[0]);
    eb = ref_lane(int'(b_i), hist_b, m_gain_b, m_ctrl[1]);
    eack = wen | ren;
    er = ren ? ref_read(int'(addr)) : 0;
    @(posedge clk);
    if (wen) begin
      case (int'(addr))
        'h1004: m_gain_a = int'(wdata[7:0]);
        'h1008: m_gain_b = int'(wdata[7:0]);
        'h100C: m_ctrl   = int'(wdata[1:0]);
        default: ;
      endcase
    end
    hist_a.push_front(int'(a_i)); void'(hist_a.pop_back());
    hist_b.push_front(int'(b_i)); void'(hist_b.pop_back());
    @(negedge clk);
    check(cur_req, "lane A out", a_o, ea);
    check(cur_req, "lane B out", b_o, eb);
    check("R8", "ack", ack, eack);
    check("R8", "err", err, 0);
    check(cur_req, "rdata", rdata, longint'(unsigned'(er)));
  endtask

  task automatic bus_wr(int a, int d);
    addr = 20'(a); wdata = 32'(d); wen = 1'b1;
    cyc();
    wen = 1'b0;
  endtask

  task automatic bus_rd(int a);
    addr = 20'(a); ren = 1'b1;
    cyc();
    ren = 1'b0;
  endtask

  task automatic run_rand(int n);
    for (int i = 0; i < n; i++) begin
      a_i = 14'($urandom);
      b_i = 14'($urandom);
      cyc();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    a_i = 14'sd1234; b_i = -14'sd77;
    repeat (3) @(negedge clk);
    check("R10", "lane A in reset", a_o, 0);
    check("R10", "lane B in reset", b_o, 0);
    check("R10", "ack in reset", ack, 0);
    model_reset();
    rst_n = 1'b1;
    a_i = '0; b_i = '0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(negedge clk);
    do_reset();
    cur_req = "R10";
    bus_rd('h1004); bus_rd('h1008); bus_rd('h100C);
    a_i = 14'sd300; b_i = -14'sd300; cyc(); cyc();

    cur_req = "R1";
    run_rand(30);

    cur_req = "R6";
    bus_rd('h1000);
    bus_wr('h1000, 0);
    bus_rd('h1000);

    cur_req = "R7";
    bus_wr('h1004, 24); bus_wr('h1008, 8);
    bus_rd('h1004); bus_rd('h1008);
    cur_req = "R2";
    run_rand(30);
    cur_req = "R7";
    bus_wr('h1004, 'h1FF); bus_wr('h1008, 'hF00);
    bus_rd('h1004); bus_rd('h1008);
    cur_req = "R2";
    run_rand(20);

    cur_req = "R3";
    bus_wr('h1004, 24); bus_wr('h1008, 255);
    a_i = 14'sd5461;  b_i = 14'sd8191;  cyc();
    a_i = 14'sd5462;  b_i = -14'sd8192; cyc();
    a_i = -14'sd5462; b_i = 14'sd33;    cyc();
    a_i = -14'sd5463; b_i = -14'sd33;   cyc();
    a_i = 14'sd8191;  b_i = 14'sd32;    cyc();
    a_i = -14'sd8192; b_i = -14'sd32;   cyc();
    run_rand(20);

    cur_req = "R4";
    bus_wr('h1004, 16); bus_wr('h1008, 16);
    run_rand(5);
    cur_req = "R5";
    bus_wr('h100C, 1);
    bus_rd('h100C);
    cur_req = "R4";
    run_rand(15);
    a_i = 14'sd1000; b_i = -14'sd999;
    repeat (6) cyc();
    a_i = -14'sd8192; b_i = 14'sd8191;
    repeat (6) cyc();
    cur_req = "R5";
    bus_wr('h100C, 'hFFFFFFFE);
    bus_rd('h100C);
    run_rand(15);
    bus_wr('h100C, 3);
    bus_wr('h1004, 40); bus_wr('h1008, 200);
    cur_req = "R4";
    run_rand(25);

    cur_req = "R9";
    bus_rd('h1010); bus_rd('h0000); bus_rd('h0100C);
    bus_wr('h1014, 99); bus_wr('h2004, 99); bus_wr('h0004, 99);
    bus_rd('h1004); bus_rd('h1008); bus_rd('h100C);

    cur_req = "R8";
    addr = 20'h1000; ren = 1'b1;
    repeat (3) cyc();
    ren = 1'b0;
    cyc(); cyc();

    cur_req = "R10";
    do_reset();
    bus_rd('h1004); bus_rd('h1008); bus_rd('h100C);
    run_rand(10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule